// File: doc/BRIEF.md
# Register Stack with Full and Empty Flags

This block is a last-in, first-out store of 64 data words held in flip-flops. A stack pointer selects the top word. A push first advances the pointer and then writes the incoming word into the entry the pointer now selects. A pop first reads the entry under the pointer and then moves the pointer back. Because of this pre-increment and post-decrement scheme, the first word pushed onto an empty stack lands in entry 1, and entry 0 is the last entry to fill.

Two status flags describe the fill state. The full flag rises when a push wraps the pointer to zero. The empty flag rises when a pop brings the pointer back to zero. The block guards against misuse. It refuses a push while full, a pop while empty, and a push and pop requested together. It reports each refusal with a one-cycle error pulse and leaves all state unchanged.

Popped data is registered. It appears together with a valid strobe in the cycle after the request.

Top module: `lifo_regstack`

## Requirements
- R1: While the synchronous active-low reset is low, the block clears its state at each clock edge. After that edge, the pointer reads 0, empty reads 1, full reads 0, and the error and pop-valid outputs read 0.
- R2: A push accepted while full is 0 (push high, pop low) advances the pointer by one, modulo 64. In the following cycle empty reads 0.
- R3: After an accepted push, full reads 1 exactly when the new pointer is 0. Sixty-four pushes from the empty state therefore set full.
- R4: An accepted pop (pop high, push low, empty 0) raises the pop-valid output for one cycle, in the cycle after the request. In that cycle the pop-data output carries the word stored at the pointer value held before the pop.
- R5: After an accepted pop, the pointer is one less, modulo 64, and full reads 0. Empty reads 1 exactly when the new pointer is 0.
- R6: A push while full is ignored. The pointer, the flags and the stored words are unchanged, and the error output is 1 in the next cycle.
- R7: A pop while empty is ignored. The pointer and the flags are unchanged, pop-valid stays 0, and the error output is 1 in the next cycle.
- R8: Push and pop requested in the same cycle are refused as an error. No state changes, and the error output is 1 in the next cycle.
- R9: Words leave in the reverse of their push order across the whole depth. This includes the 64th word, which is held in entry 0 and is the first to come back out.
- R10: The error output is high only in the cycle that follows a refused request. After any accepted request or idle cycle, it reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push_i | input | 1 | Push request for this cycle |
| pop_i | input | 1 | Pop request for this cycle |
| push_data_i | input | DATA_W (8) | Word to push |
| pop_data_o | output | DATA_W (8) | Popped word, registered |
| pop_valid_o | output | 1 | pop_data_o carries a fresh word this cycle |
| sp_o | output | ADDR_W (6) | Current stack pointer |
| full_o | output | 1 | Stack holds 64 words |
| empty_o | output | 1 | Stack holds no words |
| err_o | output | 1 | One-cycle pulse after a refused request |

## Verification
The assertions check the following on every cycle:
- the pointer step and flag update after each accepted push or pop;
- the frozen state and error pulse after each refusal;
- that the two flags are never high together;
- that a pop-valid strobe always follows an accepted read.

Only the bench's scenarios can show the data itself. Those scenarios cover:
- the reverse order of words across a complete fill and drain;
- that the word in entry 0 comes back first;
- that a refused push leaves the stored words intact;
- a reset while the stack holds data.

// File: rtl/lifo_pkg.sv
// Package: lifo_pkg
// Shared types for the register stack. The command enumeration names
// the four outcomes of one cycle's request pair after protection checks.
package lifo_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE   = 2'b00,
        CMD_PUSH   = 2'b01,
        CMD_POP    = 2'b10,
        CMD_REJECT = 2'b11
    } lifo_cmd_e;

endpackage

// File: rtl/lifo_cmd_decode.sv
// Module: lifo_cmd_decode
// Classifies the push/pop request pair against the current flags.
// It yields exactly one of idle, accepted push, accepted pop or refusal.
// Assumes the flags are registered values from the pointer controller.
module lifo_cmd_decode
    import lifo_pkg::*;
(
    input  logic push_i,
    input  logic pop_i,
    input  logic full_i,
    input  logic empty_i,
    output logic push_acc_o,
    output logic pop_acc_o,
    output logic reject_o
);

    lifo_cmd_e cmd;

    // Pick the outcome for this cycle's request pair
    always_comb begin
        unique case ({pop_i, push_i})
            2'b00:   cmd = CMD_IDLE;
            2'b01:   cmd = full_i  ? CMD_REJECT : CMD_PUSH;
            2'b10:   cmd = empty_i ? CMD_REJECT : CMD_POP;
            default: cmd = CMD_REJECT;
        endcase
    end

    // Fan the outcome out as one-hot strobes
    always_comb begin
        push_acc_o = (cmd == CMD_PUSH);
        pop_acc_o  = (cmd == CMD_POP);
        reject_o   = (cmd == CMD_REJECT);
    end

endmodule

// File: rtl/lifo_ptr_ctrl.sv
// Module: lifo_ptr_ctrl
// Owns the stack pointer, the full/empty flags and the error pulse.
// A push pre-increments the pointer and presents the new value as the
// write address. A pop post-decrements it. The flags follow the wrapped
// pointer value. Assumes at most one of the three strobes is high per cycle.
module lifo_ptr_ctrl #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_acc_i,
    input  logic              pop_acc_i,
    input  logic              reject_i,
    output logic [ADDR_W-1:0] sp_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic              full_o,
    output logic              empty_o,
    output logic              err_o
);

    localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ZERO = '0;

    logic [ADDR_W-1:0] sp_q;
    logic [ADDR_W-1:0] sp_inc;
    logic [ADDR_W-1:0] sp_dec;
    logic              full_q;
    logic              empty_q;
    logic              err_q;

    // Neighbouring pointer values, wrapping modulo the depth
    always_comb begin
        sp_inc = sp_q + ONE;
        sp_dec = sp_q - ONE;
    end

    // Pointer register: advance on push, retreat on pop
    always_ff @(posedge clk) begin
        if (!rst_n)          sp_q <= ZERO;
        else if (push_acc_i) sp_q <= sp_inc;
        else if (pop_acc_i)  sp_q <= sp_dec;
    end

    // Flags: judged on the wrapped pointer after the move
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q  <= 1'b0;
            empty_q <= 1'b1;
        end else if (push_acc_i) begin
            full_q  <= (sp_inc == ZERO);
            empty_q <= 1'b0;
        end else if (pop_acc_i) begin
            full_q  <= 1'b0;
            empty_q <= (sp_dec == ZERO);
        end
    end

    // Error pulse: one cycle after each refused request
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= reject_i;
    end

    assign sp_o      = sp_q;
    assign wr_addr_o = sp_inc;
    assign full_o    = full_q;
    assign empty_o   = empty_q;
    assign err_o     = err_q;

    // R2
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_acc_i |=> (sp_o == $past(sp_o) + ONE) && !empty_o);

    // R3
    full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_acc_i |=> (full_o == (sp_o == ZERO)));

    // R5
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_acc_i |=> (sp_o == $past(sp_o) - ONE) && !full_o
                      && (empty_o == (sp_o == ZERO)));

    // R6
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reject_i |=> $stable(sp_o) && $stable(full_o) && $stable(empty_o) && err_o);

    // R10
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reject_i |=> !err_o);

    // R3
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o));

endmodule

// File: rtl/lifo_slot_store.sv
// Module: lifo_slot_store
// Flip-flop storage of DEPTH words with one write port and one
// registered read port. A per-slot write enable is decoded from the
// write address. The read word and its valid strobe are registered, so
// they appear one cycle after the read request. Assumes write and read
// are never requested in the same cycle.
module lifo_slot_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] slot_q [DEPTH];
    logic [DEPTH-1:0]  slot_we;
    logic [DATA_W-1:0] rd_data_q;
    logic              rd_valid_q;

    // Per-slot write enables decoded from the address
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot_we
        assign slot_we[i] = wr_en_i && (wr_addr_i == ADDR_W'(i));
    end

    // Storage: each slot loads when its enable is high
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n)          slot_q[i] <= '0;
            else if (slot_we[i]) slot_q[i] <= wr_data_i;
        end
    end

    // Registered read word, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_data_q <= '0;
        else if (rd_en_i) rd_data_q <= slot_q[rd_addr_i];
    end

    // Read strobe, one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid_q <= 1'b0;
        else        rd_valid_q <= rd_en_i;
    end

    assign rd_data_o  = rd_data_q;
    assign rd_valid_o = rd_valid_q;

    // R8
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && rd_en_i));

    // R4
    rd_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rd_valid_o);

    // R7
    rd_valid_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> !rd_valid_o);

endmodule

// File: rtl/lifo_regstack.sv
// Module: lifo_regstack
// Register stack top level. It ties together the request decoder, the
// pointer and flag controller, and the flip-flop storage. The write
// address is the pre-incremented pointer; the read address is the
// current pointer. Assumes push_data_i is valid whenever push_i is high.
module lifo_regstack #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] push_data_i,
    output logic [DATA_W-1:0] pop_data_o,
    output logic              pop_valid_o,
    output logic [ADDR_W-1:0] sp_o,
    output logic              full_o,
    output logic              empty_o,
    output logic              err_o
);

    logic              push_acc;
    logic              pop_acc;
    logic              reject;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] sp;
    logic              full;
    logic              empty;

    lifo_cmd_decode u_decode (
        .push_i     (push_i),
        .pop_i      (pop_i),
        .full_i     (full),
        .empty_i    (empty),
        .push_acc_o (push_acc),
        .pop_acc_o  (pop_acc),
        .reject_o   (reject)
    );

    lifo_ptr_ctrl #(.ADDR_W(ADDR_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_acc_i (push_acc),
        .pop_acc_i  (pop_acc),
        .reject_i   (reject),
        .sp_o       (sp),
        .wr_addr_o  (wr_addr),
        .full_o     (full),
        .empty_o    (empty),
        .err_o      (err_o)
    );

    lifo_slot_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (push_acc),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (push_data_i),
        .rd_en_i    (pop_acc),
        .rd_addr_i  (sp),
        .rd_data_o  (pop_data_o),
        .rd_valid_o (pop_valid_o)
    );

    assign sp_o    = sp;
    assign full_o  = full;
    assign empty_o = empty;

    // R8
    dual_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> err_o && !pop_valid_o && $stable(sp_o));

    // R7
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && empty_o) |=> err_o && !pop_valid_o && empty_o);

endmodule

// File: tb/lifo_regstack_tb_top.sv
`timescale 1ns/1ps
// Bench: a queue-based reference model, compared on every clock.
module lifo_regstack_tb_top;

    localparam int DW    = 8;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_i = 1'b0;
    logic          pop_i = 1'b0;
    logic [DW-1:0] push_data_i = '0;
    logic [DW-1:0] pop_data_o;
    logic          pop_valid_o;
    logic [AW-1:0] sp_o;
    logic          full_o;
    logic          empty_o;
    logic          err_o;

    int vectors = 0;
    int fails   = 0;
    int model_q[$];

    always #4 clk = ~clk;

    lifo_regstack #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
        .push_data_i(push_data_i), .pop_data_o(pop_data_o),
        .pop_valid_o(pop_valid_o), .sp_o(sp_o), .full_o(full_o),
        .empty_o(empty_o), .err_o(err_o)
    );

    task automatic chk(string tag, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Apply a reset of two cycles and check the cleared state (R1)
    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        model_q.delete();
        chk("R1", "sp", int'(sp_o), 0);
        chk("R1", "empty", int'(empty_o), 1);
        chk("R1", "full", int'(full_o), 0);
        chk("R1", "err", int'(err_o), 0);
        chk("R1", "pop_valid", int'(pop_valid_o), 0);
        rst_n = 1'b1;
    endtask

    // One cycle: drive at negedge, update model at posedge, compare at next negedge
    task automatic step(bit pu, bit po, logic [DW-1:0] d, string dtag = "R4");
        int    sz;
        bit    rej;
        bit    acc_push;
        bit    acc_pop;
        int    popped;
        string tag;
        push_i      = pu;
        pop_i       = po;
        push_data_i = d;
        popped      = 0;
        @(posedge clk);
        sz       = model_q.size();
        acc_push = pu && !po && (sz < DEPTH);
        acc_pop  = po && !pu && (sz > 0);
        rej      = (pu || po) && !acc_push && !acc_pop;
        if (pu && po)             tag = "R8";
        else if (pu && sz == DEPTH) tag = "R6";
        else if (po && sz == 0)   tag = "R7";
        else if (acc_push)        tag = (sz == DEPTH - 1) ? "R3" : "R2";
        else if (acc_pop)         tag = "R5";
        else                      tag = "R10";
        if (acc_push) model_q.push_back(int'(d));
        if (acc_pop)  popped = model_q.pop_back();
        @(negedge clk);
        push_i = 1'b0;
        pop_i  = 1'b0;
        sz = model_q.size();
        chk(tag, "sp", int'(sp_o), sz % DEPTH);
        chk(tag, "full", int'(full_o), int'(sz == DEPTH));
        chk(tag, "empty", int'(empty_o), int'(sz == 0));
        chk(rej ? tag : "R10", "err", int'(err_o), int'(rej));
        chk(acc_pop ? "R4" : tag, "pop_valid", int'(pop_valid_o), int'(acc_pop));
        if (acc_pop) chk(dtag, "pop_data", int'(pop_data_o), popped);
    endtask

    initial begin
        #(8ns * 100000);
        fails++;
        $display("FAIL R10 watchdog: actual hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R7: pop on empty is refused
        step(1'b0, 1'b1, 8'h00);
        // R2 / R4 / R5: a few pushes then pops
        step(1'b1, 1'b0, 8'hA1);
        step(1'b1, 1'b0, 8'hB2);
        step(1'b1, 1'b0, 8'hC3);
        step(1'b0, 1'b0, 8'h00);
        step(1'b0, 1'b1, 8'h00);
        // R8: simultaneous request is refused
        step(1'b1, 1'b1, 8'h55);
        step(1'b0, 1'b1, 8'h00);
        step(1'b0, 1'b1, 8'h00);
        step(1'b0, 1'b1, 8'h00);
        // R3 / R9: fill all entries, then refuse one more (R6)
        for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, DW'(8'h40 + i * 3));
        step(1'b1, 1'b0, 8'hEE);
        step(1'b1, 1'b1, 8'hEF);
        // R9: drain and check reverse order, entry 0 first
        for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, 8'h00, "R9");
        step(1'b0, 1'b1, 8'h00);
        // R1: reset while holding data
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, DW'(i + 1));
        do_reset();
        step(1'b0, 1'b1, 8'h00);
        // Mixed traffic: push-leaning then pop-leaning
        for (int i = 0; i < 3000; i++) begin
            int r;
            int lean;
            r    = int'($urandom_range(99));
            lean = ((i / 500) % 2 == 0) ? 65 : 35;
            if (r < 6)         step(1'b1, 1'b1, DW'($urandom));
            else if (r < 10)   step(1'b0, 1'b0, 8'h00);
            else if (r < lean) step(1'b1, 1'b0, DW'($urandom), "R9");
            else               step(1'b0, 1'b1, 8'h00, "R9");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule